// File: doc/BRIEF.md
# Shared Memory Port Arbiter with Exclusive Ownership

This block sits in front of one shared memory port and decides, cycle by cycle, which of N masters (four by default) may use it. Every master presents a request, a write flag, an address, write data and an ownership flag. When the port is free, one requesting master is chosen in rotating order. That master receives a single-cycle grant, and its transfer is steered onto the memory port in that same cycle.

A master that needs an indivisible read-modify-write raises its ownership flag together with its read request. Once the read is granted, the port belongs to that master alone. It can idle while it computes the new value, and it can then issue the write. Every other master stays pending until the owner lowers the flag. The cycle in which the flag drops grants nobody, and normal rotating arbitration resumes on the cycle after it. Two masters that each set a different bit of the same word therefore always leave both bits set.

Top module: `shared_port_arbiter`

## Requirements
- R1: In any cycle at most one bit of `gnt` is high.
- R2: A grant goes only to a master whose `req` bit is high. A master holding `req` high stays pending, with no grant, until it is selected.
- R3: Without ownership, the master granted is the first requesting index found by searching upward, with wrap-around, from the index one above the last granted master.
- R4: After reset no master owns the port and the search starts at master 0, so with every master requesting, master 0 is granted first.
- R5: A master that is granted while its `lock` bit is high becomes the owner. While ownership is held, only the owner can be granted, and other requests receive no grant.
- R6: Ownership persists through cycles in which the owner does not request, as long as its `lock` bit stays high.
- R7: In the first cycle the owner's `lock` bit is low, ownership ends and no master is granted. On the next cycle the rotating selection applies again, searching from one above the owner.
- R8: In a cycle with a grant, `mem_en` is 1 and `mem_we`, `mem_addr` and `mem_wdata` equal the granted master's `we`, address slice and data slice (master i uses bits [i*AW +: AW] and [i*DW +: DW]). With no grant, `mem_en` is 0.
- R9: Two masters each performing an owned read, one idle cycle, and an owned write that sets one bit of the same word starting from 0xF0 (bits 0 and 1) leave the word at 0xF3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Per-master transfer request, held until granted |
| lock | input | N | Per-master ownership flag |
| we | input | N | Per-master write (1) or read (0) |
| addr | input | N*AW | Per-master address, packed by master index |
| wdata | input | N*DW | Per-master write data, packed by master index |
| gnt | output | N | One-hot grant pulse, one per transfer |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |

## Verification
The selection logic is tried with all masters requesting at once, which shows the starting point after reset and the sequential order. Sparse pairs of requests that straddle the wrap point tell a true rotating search apart from fixed priority. Owned sequences with an idle owner and a competing requester show whether blocking holds and whether the release cycle is empty. Two interleaved bit-setting read-modify-writes on one word distinguish an indivisible sequence (0xF3) from a lost update (0xF1 or 0xF2).

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Next index in a ring of n entries.
  function automatic int ring_next(input int cur, input int n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] elig,
  output logic [N-1:0] pick
);
  import arb_pkg::*;

  logic [IW-1:0] start_q;
  logic [IW-1:0] pick_idx;
  logic          found;

  always_comb begin
    pick     = '0;
    pick_idx = '0;
    found    = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(start_q) + k) % N;
      if (!found && elig[idx]) begin
        found     = 1'b1;
        pick[idx] = 1'b1;
        pick_idx  = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     start_q <= '0;
    else if (found) start_q <= IW'(ring_next(int'(pick_idx), N));
  end

  // R1
  one_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));
  // R2
  pick_in_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick & ~elig) == '0);
endmodule

// File: rtl/lock_tracker.sv
module lock_tracker #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lock,
  input  logic [N-1:0] gnt,
  output logic         held,
  output logic [N-1:0] owner_mask,
  output logic         release_now
);
  logic [IW-1:0] owner_q;
  logic          held_q;
  logic          take_now;
  logic [IW-1:0] gnt_idx;

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < N; i++)
      if (gnt[i]) gnt_idx = IW'(i);
  end

  assign held        = held_q;
  assign release_now = held_q && !lock[owner_q];
  assign take_now    = !held_q && (|gnt) && lock[gnt_idx];

  always_comb begin
    owner_mask = '0;
    owner_mask[owner_q] = held_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else if (take_now) begin
      held_q  <= 1'b1;
      owner_q <= gnt_idx;
    end else if (release_now) begin
      held_q  <= 1'b0;
    end
  end

  // R5
  only_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> ((gnt & ~owner_mask) == '0));
  // R6
  keep_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && lock[owner_q]) |=> (held_q && $stable(owner_q)));
  // R7
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_now |-> (gnt == '0));
  // R7
  release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_now |=> !held_q);
endmodule

// File: rtl/port_mux.sv
module port_mux #(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic [N-1:0]    gnt,
  input  logic [N-1:0]    we,
  input  logic [N*AW-1:0] addr,
  input  logic [N*DW-1:0] wdata,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata
);
  always_comb begin
    mem_en    = |gnt;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    for (int i = 0; i < N; i++) begin
      mem_we    = mem_we    | (gnt[i] & we[i]);
      mem_addr  = mem_addr  | ({AW{gnt[i]}} & addr[i*AW +: AW]);
      mem_wdata = mem_wdata | ({DW{gnt[i]}} & wdata[i*DW +: DW]);
    end
  end
endmodule

// File: rtl/shared_port_arbiter.sv
module shared_port_arbiter #(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic [N-1:0]    lock,
  input  logic [N-1:0]    we,
  input  logic [N*AW-1:0] addr,
  input  logic [N*DW-1:0] wdata,
  output logic [N-1:0]    gnt,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata
);
  logic         held;
  logic         release_now;
  logic [N-1:0] owner_mask;
  logic [N-1:0] elig;

  always_comb begin
    if (!held)           elig = req;
    else if (release_now) elig = '0;
    else                  elig = req & owner_mask;
  end

  rr_picker #(.N(N)) u_pick (
    .clk(clk), .rst_n(rst_n), .elig(elig), .pick(gnt)
  );

  lock_tracker #(.N(N)) u_lock (
    .clk(clk), .rst_n(rst_n), .lock(lock), .gnt(gnt),
    .held(held), .owner_mask(owner_mask), .release_now(release_now)
  );

  port_mux #(.N(N), .AW(AW), .DW(DW)) u_mux (
    .gnt(gnt), .we(we), .addr(addr), .wdata(wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // R2
  gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  // R8
  idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) |-> !mem_en);
endmodule

// File: tb/shared_port_arbiter_tb.sv
module shared_port_arbiter_tb;
  localparam int N = 4, AW = 4, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req = '0, lock = '0, we = '0;
  logic [N*AW-1:0] addr = '0;
  logic [N*DW-1:0] wdata = '0;
  logic [N-1:0] gnt;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shared_port_arbiter #(.N(N), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .we(we),
    .addr(addr), .wdata(wdata), .gnt(gnt), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always_ff @(posedge clk)
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
  assign rdata = mem[mem_addr];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    req = '0; lock = '0; we = '0; addr = '0; wdata = '0;
  endtask

  task automatic set_m(input int m, input bit r, input bit l, input bit w,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    req[m] = r; lock[m] = l; we[m] = w;
    addr[m*AW +: AW] = a; wdata[m*DW +: DW] = d;
  endtask

  task automatic t_reset_order();
    @(negedge clk); clear_in(); #1;
    chk("R8 idle gnt", 32'(gnt), 0);
    chk("R8 idle mem_en", 32'(mem_en), 0);
    req = 4'b1111;
    for (int k = 0; k < N; k++) begin
      #1;
      if (k == 0) chk("R4 first grant", 32'(gnt), 1);
      else        chk("R3 sequential grant", 32'(gnt), 32'(1 << k));
      chk("R1 single grant", 32'($countones(gnt)), 1);
      @(negedge clk); req[k] = 1'b0;
    end
    #1; chk("R2 no request no grant", 32'(gnt), 0);
  endtask

  task automatic t_wrap();
    @(negedge clk); clear_in(); req = 4'b0101; #1;
    chk("R3 wrap to 0", 32'(gnt), 32'h1);
    @(negedge clk); #1;
    chk("R3 skip to 2", 32'(gnt), 32'h4);
    @(negedge clk); req = 4'b1001; #1;
    chk("R3 next is 3", 32'(gnt), 32'h8);
    @(negedge clk); clear_in();
  endtask

  task automatic t_mux();
    @(negedge clk); clear_in(); set_m(2, 1, 0, 1, 4'h5, 8'hA5); #1;
    chk("R8 gnt", 32'(gnt), 32'h4);
    chk("R8 mem_en", 32'(mem_en), 1);
    chk("R8 mem_we", 32'(mem_we), 1);
    chk("R8 mem_addr", 32'(mem_addr), 32'h5);
    chk("R8 mem_wdata", 32'(mem_wdata), 32'hA5);
    @(negedge clk); clear_in(); #1;
    chk("R8 stored", 32'(mem[5]), 32'hA5);
  endtask

  task automatic t_lock_idle();
    @(negedge clk); clear_in(); set_m(1, 1, 1, 0, 4'h5, 0); #1;
    chk("R5 owner granted", 32'(gnt), 32'h2);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); set_m(1, 0, 1, 0, 0, 0); set_m(3, 1, 0, 0, 0, 0); #1;
      chk("R6 idle owner blocks others", 32'(gnt), 0);
    end
    @(negedge clk); set_m(1, 1, 1, 1, 4'h5, 8'h3C); #1;
    chk("R5 owner regranted", 32'(gnt), 32'h2);
    @(negedge clk); set_m(1, 0, 0, 0, 0, 0); #1;
    chk("R7 release cycle empty", 32'(gnt), 0);
    @(negedge clk); #1;
    chk("R7 arbitration resumes", 32'(gnt), 32'h8);
    @(negedge clk); clear_in();
  endtask

  task automatic t_rmw(input logic [AW-1:0] a);
    int ph [2];
    logic [DW-1:0] v [2];
    int intrude = 0;
    @(negedge clk); clear_in(); set_m(3, 1, 0, 1, a, 8'hF0); #1;
    chk("R8 seed write", 32'(gnt), 32'h8);
    ph[0] = 0; ph[1] = 0; v[0] = 0; v[1] = 0;
    for (int cyc = 0; cyc < 40 && !(ph[0] == 4 && ph[1] == 4); cyc++) begin
      @(negedge clk);
      for (int m = 0; m < 2; m++)
        set_m(m, ph[m] == 0 || ph[m] == 2, ph[m] < 3, ph[m] == 2, a,
              v[m] | DW'(1 << m));
      set_m(3, 0, 0, 0, 0, 0);
      #1;
      if (ph[0] >= 1 && ph[0] <= 3 && gnt[1]) intrude++;
      for (int m = 0; m < 2; m++) begin
        if (ph[m] == 0 && gnt[m]) begin v[m] = rdata; ph[m] = 1; end
        else if (ph[m] == 1) ph[m] = 2;
        else if (ph[m] == 2 && gnt[m]) ph[m] = 3;
        else if (ph[m] == 3) ph[m] = 4;
      end
    end
    chk("R5 no intrusion during owned sequence", 32'(intrude), 0);
    chk("R9 both sequences finished", 32'(ph[0] + ph[1]), 8);
    @(negedge clk); clear_in(); set_m(3, 1, 0, 0, a, 0); #1;
    chk("R9 word holds both bits", 32'(rdata), 32'hF3);
    @(negedge clk); clear_in();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_order();
    t_wrap();
    t_mux();
    t_lock_idle();
    t_rmw(4'h9);
    t_rmw(4'hC);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule